// File: doc/BRIEF.md
# Serial Flash Status-Register Controller

This block is the command and status side of a serial NOR flash. A front end that has already framed the serial bus delivers one decoded instruction per cycle: an opcode, a block address and one data byte, marked valid for a single cycle. The block keeps three 8-bit status registers. Each has a working (volatile) copy that drives behaviour and a non-volatile shadow that survives resets. It also keeps the write-enable latch and a busy flag timed by a programmable operation counter.

Every instruction is answered, one cycle after it is presented, by a one-cycle accept or reject pulse. Status reads also return a data byte in that cycle. Program and erase requests are gated by the write-enable latch, by range or per-block protection, and by one-time lock bits for three security regions. A write-protect input guards the status registers. A two-instruction software reset, a volatile-write prefix and a busy-time instruction filter complete the control set. Two outputs report whether the multipurpose pin currently acts as hold or as reset.

Top module: `flash_sr_ctrl`

## Requirements
- R1: Program (02h), block erase (20h, D8h), security program/erase (42h, 44h) and non-volatile status writes (01h, 31h, 11h without prefix) are accepted only while the write-enable latch is 1. 06h sets the latch and 04h clears it. A rejected instruction leaves the latch unchanged.
- R2: A 50h prefix makes only the immediately following instruction, if it is 01h, 31h or 11h, a volatile write: only the working copy changes and the shadow is untouched. Any other following instruction cancels the prefix.
- R3: 50h drives the write-enable latch to 0. A volatile write neither needs the latch nor sets it.
- R4: A volatile write never raises busy. An accepted non-volatile write, program or erase raises busy in the response cycle for BUSY_CYC cycles. Busy and the write-enable latch then both clear.
- R5: porN loads every shadow and working copy from the parameter defaults. A hardware reset (rstN low) or a software reset reloads every working copy from its shadow and clears busy, the latch and both armed prefixes.
- R6: 99h performs a software reset only when the previous instruction was 66h. Otherwise 99h is rejected and has no effect.
- R7: While busy is 1, only 05h, 35h, 15h, 66h and 99h are accepted. All others, including array read 03h and 06h, are rejected.
- R8: Status-2 bits 5:3 are lock bits for security regions 1..3. They are changed only by non-volatile writes, can only be set, and never return to 0. 42h/44h select the region with address bits 1:0. They are rejected when the region is 0 or its lock bit is 1.
- R9: With status-3 bit 2 (WPS) at 0, protection follows status-1 BP = bits 4:2 and TB = bit 5, and status-2 CMP = bit 6. N = 0 if BP = 0, else min(2^(BP-1), NUM_BLK) blocks are protected: the top N when TB = 0, the bottom N when TB = 1. CMP = 1 inverts the set. Program or erase of a protected block is rejected.
- R10: With WPS = 1, per-block lock bits decide protection and the range bits are ignored. All lock bits are set after any reset. 36h sets and 39h clears the bit of the addressed block, without needing the latch.
- R11: While wpN is 0, every status write (volatile or not) is rejected. wpN does not affect program or erase.
- R12: With QE (status-2 bit 1) at 0, status-3 bit 7 selects the pin function: pinHoldMode when 0, pinResetMode when 1. With QE at 1, both outputs are 0.
- R13: 05h/35h/15h return status 1/2/3 on rdData with rdValid in the response cycle. Status-1 bit 0 reads busy and bit 1 reads the write-enable latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Power-on reset, active low, synchronous |
| rstN | input | 1 | Hardware reset, active low, synchronous |
| cmdValid | input | 1 | Instruction valid for this cycle |
| cmdCode | input | 8 | Instruction opcode |
| cmdAddr | input | BLK_W | Block index, or security region in bits 1:0 |
| cmdData | input | 8 | Data byte for status writes |
| wpN | input | 1 | Write-protect input, active low |
| acceptStb | output | 1 | Instruction accepted (response cycle) |
| rejectStb | output | 1 | Instruction rejected (response cycle) |
| rdValid | output | 1 | Status read data valid |
| rdData | output | 8 | Status read data |
| busy | output | 1 | Internal operation in progress |
| wel | output | 1 | Write-enable latch |
| pinHoldMode | output | 1 | Multipurpose pin acts as hold |
| pinResetMode | output | 1 | Multipurpose pin acts as reset |

## Verification
The assertions assume that cmdValid is a single-cycle pulse carrying a known opcode. They also assume both resets are held for at least one clock edge, so the first sampled cycle after reset starts from the reset values. The bench presents each instruction for one cycle and leaves an idle cycle before the next. It raises resets only between instructions. It waits for busy to fall before starting a new timed operation, except in the scenario that deliberately probes the busy-time filter.

// File: rtl/flash_sr_pkg.sv
package flash_sr_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_VPFX  = 8'h50;
  localparam logic [7:0] OP_WRSR1 = 8'h01;
  localparam logic [7:0] OP_WRSR2 = 8'h31;
  localparam logic [7:0] OP_WRSR3 = 8'h11;
  localparam logic [7:0] OP_RDSR1 = 8'h05;
  localparam logic [7:0] OP_RDSR2 = 8'h35;
  localparam logic [7:0] OP_RDSR3 = 8'h15;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_ERS4  = 8'h20;
  localparam logic [7:0] OP_ERS64 = 8'hD8;
  localparam logic [7:0] OP_SPROG = 8'h42;
  localparam logic [7:0] OP_SERS  = 8'h44;
  localparam logic [7:0] OP_BLKLK = 8'h36;
  localparam logic [7:0] OP_BLKUL = 8'h39;
  localparam logic [7:0] OP_RSTEN = 8'h66;
  localparam logic [7:0] OP_RST   = 8'h99;

  // writable bits of each status register
  localparam logic [7:0] MASK_S1 = 8'hFC;
  localparam logic [7:0] MASK_S2 = 8'h42;
  localparam logic [7:0] MASK_LB = 8'h38;
  localparam logic [7:0] MASK_S3 = 8'h84;

  typedef struct packed {
    logic       wrVol;
    logic       wrNv;
    logic       rdEn;
    logic [1:0] regSel;
    logic       blkLock;
    logic       blkUnlock;
    logic       swReset;
  } strobe_t;
endpackage

// File: rtl/flash_sr_ctrl_fsm.sv
module flash_sr_ctrl_fsm
  import flash_sr_pkg::*;
#(
  parameter int BUSY_CYC = 24
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [7:0] cmdCode,
  input  logic       wpN,
  input  logic       blkProt,
  input  logic       secOk,
  output strobe_t    st,
  output logic       acceptStb,
  output logic       rejectStb,
  output logic       busy,
  output logic       wel
);
  localparam int CNT_W = $clog2(BUSY_CYC + 1);

  logic [CNT_W-1:0] cnt;
  logic volArmed, rstArmed;
  logic acc, rej, startOp, setWel, clrWel;

  function automatic logic [1:0] regIdx(input logic [7:0] c);
    if (c == OP_WRSR1 || c == OP_RDSR1) return 2'd0;
    if (c == OP_WRSR2 || c == OP_RDSR2) return 2'd1;
    return 2'd2;
  endfunction

  always_comb begin
    st = '0;
    acc = 1'b0;
    rej = 1'b0;
    startOp = 1'b0;
    setWel = 1'b0;
    clrWel = 1'b0;
    st.regSel = regIdx(cmdCode);
    if (cmdValid) begin
      if (busy && !(cmdCode inside {OP_RDSR1, OP_RDSR2, OP_RDSR3, OP_RSTEN, OP_RST})) begin
        rej = 1'b1;
      end else begin
        case (cmdCode)
          OP_WREN: begin acc = 1'b1; setWel = 1'b1; end
          OP_WRDI: begin acc = 1'b1; clrWel = 1'b1; end
          OP_VPFX: begin acc = 1'b1; clrWel = 1'b1; end
          OP_WRSR1, OP_WRSR2, OP_WRSR3: begin
            if (!wpN) rej = 1'b1;
            else if (volArmed) begin acc = 1'b1; st.wrVol = 1'b1; end
            else if (wel) begin acc = 1'b1; st.wrNv = 1'b1; startOp = 1'b1; end
            else rej = 1'b1;
          end
          OP_PROG, OP_ERS4, OP_ERS64: begin
            if (wel && !blkProt) begin acc = 1'b1; startOp = 1'b1; end
            else rej = 1'b1;
          end
          OP_SPROG, OP_SERS: begin
            if (wel && secOk) begin acc = 1'b1; startOp = 1'b1; end
            else rej = 1'b1;
          end
          OP_BLKLK: begin acc = 1'b1; st.blkLock = 1'b1; end
          OP_BLKUL: begin acc = 1'b1; st.blkUnlock = 1'b1; end
          OP_READ:  acc = 1'b1;
          OP_RDSR1, OP_RDSR2, OP_RDSR3: begin acc = 1'b1; st.rdEn = 1'b1; end
          OP_RSTEN: acc = 1'b1;
          OP_RST: begin
            if (rstArmed) begin acc = 1'b1; st.swReset = 1'b1; end
            else rej = 1'b1;
          end
          default: rej = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!porN || !rstN) begin
      busy <= 1'b0;
      wel <= 1'b0;
      cnt <= '0;
      volArmed <= 1'b0;
      rstArmed <= 1'b0;
      acceptStb <= 1'b0;
      rejectStb <= 1'b0;
    end else begin
      acceptStb <= acc;
      rejectStb <= rej;
      if (cmdValid) begin
        volArmed <= acc && (cmdCode == OP_VPFX);
        rstArmed <= acc && (cmdCode == OP_RSTEN);
      end
      if (st.swReset) begin
        busy <= 1'b0;
        wel <= 1'b0;
        cnt <= '0;
      end else if (startOp) begin
        busy <= 1'b1;
        cnt <= CNT_W'(BUSY_CYC - 1);
      end else if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          wel <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (setWel) begin
        wel <= 1'b1;
      end else if (clrWel) begin
        wel <= 1'b0;
      end
    end
  end

  AST_BUSY_NEEDS_WEL: assert property (@(posedge clk) disable iff (!porN || !rstN)
    $rose(busy) |-> $past(wel)); // R1
  AST_PREFIX_CLEARS_WEL: assert property (@(posedge clk) disable iff (!porN || !rstN)
    (cmdValid && cmdCode == OP_VPFX && !busy) |=> !wel); // R3
  AST_VOL_NO_BUSY: assert property (@(posedge clk) disable iff (!porN || !rstN)
    st.wrVol |=> !busy); // R4
  AST_DONE_DROPS_WEL: assert property (@(posedge clk) disable iff (!porN || !rstN)
    $fell(busy) |-> !wel); // R4
  AST_BUSY_FILTER: assert property (@(posedge clk) disable iff (!porN || !rstN)
    (busy && cmdValid && cmdCode == OP_READ) |=> rejectStb); // R7
endmodule

// File: rtl/flash_sr_datapath.sv
module flash_sr_datapath
  import flash_sr_pkg::*;
#(
  parameter int         NUM_BLK = 16,
  parameter int         BLK_W   = 4,
  parameter logic [7:0] S1_INIT = 8'h00,
  parameter logic [7:0] S2_INIT = 8'h00,
  parameter logic [7:0] S3_INIT = 8'h00
) (
  input  logic             clk,
  input  logic             porN,
  input  logic             rstN,
  input  strobe_t          st,
  input  logic [BLK_W-1:0] cmdAddr,
  input  logic [7:0]       cmdData,
  input  logic             busyIn,
  input  logic             welIn,
  output logic             blkProt,
  output logic             secOk,
  output logic             rdValid,
  output logic [7:0]       rdData,
  output logic             pinHoldMode,
  output logic             pinResetMode
);
  logic [7:0] work1, work2, work3;
  logic [7:0] shad1, shad2, shad3;
  logic [NUM_BLK-1:0] blkLocks;
  logic [7:0] nv2;
  logic inRange;
  int unsigned protCnt, addrIdx;

  assign nv2 = (cmdData & MASK_S2) | ((shad2 | cmdData) & MASK_LB);

  always_comb begin
    protCnt = (work1[4:2] == 3'd0) ? 0 : (32'd1 << (work1[4:2] - 3'd1));
    if (protCnt > NUM_BLK) protCnt = NUM_BLK;
    addrIdx = 32'(cmdAddr);
    inRange = work1[5] ? (addrIdx < protCnt) : (addrIdx + protCnt >= NUM_BLK);
    blkProt = work3[2] ? blkLocks[cmdAddr] : (inRange ^ work2[6]);
    case (cmdAddr[1:0])
      2'd1: secOk = !work2[3];
      2'd2: secOk = !work2[4];
      2'd3: secOk = !work2[5];
      default: secOk = 1'b0;
    endcase
  end

  assign pinHoldMode  = !work2[1] && !work3[7];
  assign pinResetMode = !work2[1] &&  work3[7];

  always_ff @(posedge clk) begin
    if (!porN) begin
      shad1 <= S1_INIT & MASK_S1;
      shad2 <= S2_INIT & (MASK_S2 | MASK_LB);
      shad3 <= S3_INIT & MASK_S3;
      work1 <= S1_INIT & MASK_S1;
      work2 <= S2_INIT & (MASK_S2 | MASK_LB);
      work3 <= S3_INIT & MASK_S3;
      blkLocks <= '1;
      rdValid <= 1'b0;
      rdData <= '0;
    end else if (!rstN || st.swReset) begin
      work1 <= shad1;
      work2 <= shad2;
      work3 <= shad3;
      blkLocks <= '1;
      rdValid <= 1'b0;
    end else begin
      rdValid <= st.rdEn;
      if (st.rdEn) begin
        case (st.regSel)
          2'd0: rdData <= {work1[7:2], welIn, busyIn};
          2'd1: rdData <= work2;
          default: rdData <= work3;
        endcase
      end
      if (st.wrVol) begin
        case (st.regSel)
          2'd0: work1 <= cmdData & MASK_S1;
          2'd1: work2 <= (cmdData & MASK_S2) | (work2 & MASK_LB);
          default: work3 <= cmdData & MASK_S3;
        endcase
      end
      if (st.wrNv) begin
        case (st.regSel)
          2'd0: begin work1 <= cmdData & MASK_S1; shad1 <= cmdData & MASK_S1; end
          2'd1: begin work2 <= nv2; shad2 <= nv2; end
          default: begin work3 <= cmdData & MASK_S3; shad3 <= cmdData & MASK_S3; end
        endcase
      end
      if (st.blkLock) blkLocks[cmdAddr] <= 1'b1;
      if (st.blkUnlock) blkLocks[cmdAddr] <= 1'b0;
    end
  end

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!porN || !rstN)
    st.wrVol |=> $stable({shad1, shad2, shad3})); // R2
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!porN)
    (($past(shad2) & MASK_LB) & shad2) == ($past(shad2) & MASK_LB)); // R8
endmodule

// File: rtl/flash_sr_ctrl.sv
module flash_sr_ctrl
  import flash_sr_pkg::*;
#(
  parameter int         NUM_BLK  = 16,
  parameter int         BLK_W    = $clog2(NUM_BLK),
  parameter int         BUSY_CYC = 24,
  parameter logic [7:0] S1_INIT  = 8'h00,
  parameter logic [7:0] S2_INIT  = 8'h00,
  parameter logic [7:0] S3_INIT  = 8'h00
) (
  input  logic             clk,
  input  logic             porN,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [7:0]       cmdCode,
  input  logic [BLK_W-1:0] cmdAddr,
  input  logic [7:0]       cmdData,
  input  logic             wpN,
  output logic             acceptStb,
  output logic             rejectStb,
  output logic             rdValid,
  output logic [7:0]       rdData,
  output logic             busy,
  output logic             wel,
  output logic             pinHoldMode,
  output logic             pinResetMode
);
  strobe_t st;
  logic blkProt, secOk;

  flash_sr_ctrl_fsm #(.BUSY_CYC(BUSY_CYC)) uCtrl (
    .clk(clk), .porN(porN), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .wpN(wpN), .blkProt(blkProt), .secOk(secOk), .st(st),
    .acceptStb(acceptStb), .rejectStb(rejectStb), .busy(busy), .wel(wel)
  );

  flash_sr_datapath #(
    .NUM_BLK(NUM_BLK), .BLK_W(BLK_W),
    .S1_INIT(S1_INIT), .S2_INIT(S2_INIT), .S3_INIT(S3_INIT)
  ) uData (
    .clk(clk), .porN(porN), .rstN(rstN), .st(st), .cmdAddr(cmdAddr),
    .cmdData(cmdData), .busyIn(busy), .welIn(wel), .blkProt(blkProt),
    .secOk(secOk), .rdValid(rdValid), .rdData(rdData),
    .pinHoldMode(pinHoldMode), .pinResetMode(pinResetMode)
  );
endmodule

// File: tb/tb_flash_sr_ctrl.sv
module tb_flash_sr_ctrl;
  localparam int BLK_W = 4;

  logic clk = 1'b0;
  logic porN = 1'b0, rstN = 1'b0, cmdValid = 1'b0, wpN = 1'b1;
  logic [7:0] cmdCode = '0, cmdData = '0;
  logic [BLK_W-1:0] cmdAddr = '0;
  logic acceptStb, rejectStb, rdValid, busy, wel, pinHoldMode, pinResetMode;
  logic [7:0] rdData;

  int nChecks = 0, nFail = 0;
  logic gAcc, gRej;
  logic [7:0] gRd;

  always #2 clk = ~clk;

  flash_sr_ctrl #(.NUM_BLK(16), .BLK_W(BLK_W), .BUSY_CYC(24)) dut (
    .clk(clk), .porN(porN), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .wpN(wpN), .acceptStb(acceptStb),
    .rejectStb(rejectStb), .rdValid(rdValid), .rdData(rdData), .busy(busy),
    .wel(wel), .pinHoldMode(pinHoldMode), .pinResetMode(pinResetMode)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] c, input int a = 0, input logic [7:0] d = 8'h00);
    @(negedge clk);
    cmdValid = 1'b1; cmdCode = c; cmdAddr = a[BLK_W-1:0]; cmdData = d;
    @(negedge clk);
    cmdValid = 1'b0;
    gAcc = acceptStb; gRej = rejectStb; gRd = rdData;
  endtask

  task automatic expAcc(input string req);
    check(gAcc && !gRej, req, {gAcc, gRej}, 2'b10);
  endtask

  task automatic expRej(input string req);
    check(!gAcc && gRej, req, {gAcc, gRej}, 2'b01);
  endtask

  task automatic readSr(input int idx, input logic [7:0] exp, input string req);
    issue(idx == 1 ? 8'h05 : (idx == 2 ? 8'h35 : 8'h15));
    check(gAcc && rdValid && gRd == exp, req, gRd, exp);
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    check(!busy, "R4 busy clears", busy, 0);
  endtask

  task automatic hwReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
  endtask

  task automatic t_reset();
    readSr(1, 8'h00, "R13 sr1 after por");
    readSr(2, 8'h00, "R5 sr2 after por");
    readSr(3, 8'h00, "R5 sr3 after por");
    check(pinHoldMode && !pinResetMode, "R12 default hold", {pinHoldMode, pinResetMode}, 2'b10);
    check(!busy && !wel, "R5 idle after por", {busy, wel}, 0);
  endtask

  task automatic t_wel();
    issue(8'h02, 0); expRej("R1 program without latch");
    issue(8'h06); expAcc("R1 write enable");
    readSr(1, 8'h02, "R13 latch in sr1 bit1");
    issue(8'h02, 0); expAcc("R1 program with latch");
    check(busy, "R4 busy in response cycle", busy, 1);
    waitIdle();
    check(!wel, "R4 latch cleared at end", wel, 0);
    issue(8'h06); issue(8'h04); issue(8'h02, 0); expRej("R1 latch cleared by 04h");
  endtask

  task automatic t_range();
    issue(8'h06); issue(8'h01, 0, 8'h04); expAcc("R1 nv write sr1");
    waitIdle();
    readSr(1, 8'h04, "R9 BP=1 stored");
    issue(8'h06); issue(8'h02, 15); expRej("R9 top block protected");
    issue(8'h02, 14); expAcc("R9 block below range free");
    waitIdle();
    issue(8'h50); issue(8'h31, 0, 8'h40); expAcc("R2 volatile CMP");
    issue(8'h06); issue(8'h02, 15); expAcc("R9 CMP frees top block");
    waitIdle();
    issue(8'h06); issue(8'h02, 0); expRej("R9 CMP protects block 0");
    hwReset();
    readSr(2, 8'h00, "R5 hw reset drops volatile CMP");
    readSr(1, 8'h04, "R5 hw reset keeps nv sr1");
  endtask

  task automatic t_volatile();
    issue(8'h06); issue(8'h50); expAcc("R3 prefix accepted");
    check(!wel, "R3 latch 0 after prefix", wel, 0);
    issue(8'h11, 0, 8'h80); expAcc("R2 volatile sr3 write");
    check(!busy, "R4 no busy on volatile write", busy, 0);
    repeat (3) @(negedge clk);
    check(!busy, "R4 busy stays 0", busy, 0);
    readSr(3, 8'h80, "R2 working copy updated");
    check(!pinHoldMode && pinResetMode, "R12 reset function", {pinHoldMode, pinResetMode}, 2'b01);
    issue(8'h50); issue(8'h31, 0, 8'h02); expAcc("R2 volatile QE");
    check(!pinHoldMode && !pinResetMode, "R12 QE disables pin", {pinHoldMode, pinResetMode}, 0);
    hwReset();
    readSr(3, 8'h00, "R2 shadow untouched by volatile write");
    issue(8'h50); issue(8'h05); issue(8'h01, 0, 8'h08); expRej("R2 prefix only for next instruction");
  endtask

  task automatic t_swreset();
    issue(8'h50); issue(8'h11, 0, 8'h80);
    issue(8'h99); expRej("R6 lone 99h");
    readSr(3, 8'h80, "R6 lone 99h no effect");
    issue(8'h66); issue(8'h05); issue(8'h99); expRej("R6 99h not directly after 66h");
    issue(8'h66); issue(8'h99); expAcc("R6 66h then 99h");
    readSr(3, 8'h00, "R5 sw reset reloads shadow");
  endtask

  task automatic t_busy();
    issue(8'h06); issue(8'h20, 1); expAcc("R1 erase");
    issue(8'h03); expRej("R7 array read while busy");
    issue(8'h06); expRej("R7 write enable while busy");
    issue(8'h05);
    check(gAcc && gRd == 8'h07, "R7 status read while busy", gRd, 8'h07);
    issue(8'h66); expAcc("R7 66h while busy");
    issue(8'h99); expAcc("R7 99h while busy");
    check(!busy && !wel, "R5 sw reset aborts busy", {busy, wel}, 0);
  endtask

  task automatic t_wp();
    wpN = 1'b0;
    issue(8'h06); issue(8'h01, 0, 8'h00); expRej("R11 nv write blocked");
    issue(8'h02, 2); expAcc("R11 program not blocked");
    waitIdle();
    issue(8'h50); issue(8'h01, 0, 8'h00); expRej("R11 volatile write blocked");
    readSr(1, 8'h04, "R11 sr1 unchanged");
    wpN = 1'b1;
  endtask

  task automatic t_lock();
    issue(8'h06); issue(8'h31, 0, 8'h08); expAcc("R8 set lock 1");
    waitIdle();
    issue(8'h06); issue(8'h42, 1); expRej("R8 locked region 1");
    issue(8'h42, 0); expRej("R8 region 0 invalid");
    issue(8'h42, 2); expAcc("R8 unlocked region 2");
    waitIdle();
    issue(8'h06); issue(8'h31, 0, 8'h00); waitIdle();
    readSr(2, 8'h08, "R8 lock bit cannot clear");
  endtask

  task automatic t_wps();
    issue(8'h50); issue(8'h11, 0, 8'h04); expAcc("R10 WPS set");
    issue(8'h06); issue(8'h02, 3); expRej("R10 block locked after reset");
    issue(8'h39, 3); expAcc("R10 unlock block 3");
    issue(8'h02, 3); expAcc("R10 unlocked block programs");
    waitIdle();
    issue(8'h06); issue(8'h39, 15); issue(8'h02, 15); expAcc("R10 range bits ignored");
    waitIdle();
    issue(8'h36, 3); issue(8'h06); issue(8'h02, 3); expRej("R10 relocked block");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    porN = 1'b1; rstN = 1'b1;
    t_reset();
    t_wel();
    t_range();
    t_volatile();
    t_swreset();
    t_busy();
    t_wp();
    t_lock();
    t_wps();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    #400000;
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule